// File: doc/BRIEF.md
# Clock Controller Register Bank

This block is the software-visible register file of a clock control unit. It sits on a simple word-oriented bus with separate read and write strobes, a byte address and 32-bit data. It holds one operating-mode word, two post-divider words, control words for a main PLL and a system PLL, three clock-gating words and one power-management word. Every writable word applies its own write mask. The mode word also has one bit that each write forces to 1. One read-only word returns a fixed constant. Every other unmapped word reads as zero and ignores writes.

A downstream frequency engine uses the mode, divider and PLL words, which also appear as outputs. The bank tells that engine when to recompute: a one-cycle strobe follows any write to one of those five words. It also follows the first cycle after reset is released, so the engine computes once from the reset values. Writes to the gating words do not raise the strobe.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset the words read as follows: word 0 = 0x074b0b7b, word 1 = 0xff870b48, word 2 = 0x49fcfe7f, word 4 = 0x04001800, word 6 = 0x04043001, words 8/9/10 = 0xffffffff, word 23 = 0x80209828.
- R2: A write to word 0 stores (data & 0x3b6fdfff) with bit 26 set to 1.
- R3: A write to word 1 stores (data & 0xff9f3fff). A write to word 2 stores all 32 bits.
- R4: A write to word 4 or word 6 stores (data & 0xbfff3fff).
- R5: A write to words 8, 9 or 10 stores all 32 bits and raises no recompute strobe.
- R6: Word 23 always reads its reset value. Writes to it change nothing and raise no strobe.
- R7: Word 18 reads 0x00004040. Any other unmapped word reads 0. Writes to unmapped words change no readable state and raise no strobe.
- R8: Read data and its valid flag appear in the cycle after the read strobe. A read and a write to the same word in the same cycle return the old contents.
- R9: A write to word 0, 1, 2, 4 or 6 drives `recalc_pulse` high for exactly the following cycle. Cycles with no write keep it low.
- R10: `recalc_pulse` is high for one cycle in the first cycle after reset is released.
- R11: The word index is the byte address shifted right by 2. Address bits [1:0] are ignored.
- R12: `mode_o`, `div0_o`, `div1_o`, `mpll_o` and `spll_o` always show the stored words 0, 1, 2, 4 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| recalc_pulse | output | 1 | One-cycle recompute strobe |
| mode_o | output | 32 | Stored mode word |
| div0_o | output | 32 | Stored first divider word |
| div1_o | output | 32 | Stored second divider word |
| mpll_o | output | 32 | Stored main PLL control word |
| spll_o | output | 32 | Stored system PLL control word |

## Verification
Writing all ones to each masked word shows its exact mask. Writing a pattern with only masked-off bits set, such as 0x40004000 to the system PLL word, shows that those bits really are discarded and not just overwritten. Writing zeros to the mode word separates the forced bit from data that was merely kept. Reads at addresses with nonzero low bits show that only the word index selects a register. A read and a write to one word in the same cycle show that the old value is returned. Gating, power-management and unmapped writes are mixed in with configuration writes, so the bench confirms that the strobe tracks only the configuration words and lasts one cycle.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int DATA_W    = 32;
  localparam int NUM_SLOTS = 9;

  // Storage slots, in the order used by the generate loop in the top module.
  typedef enum logic [3:0] {
    SLOT_MODE  = 4'd0,
    SLOT_DIV0  = 4'd1,
    SLOT_DIV1  = 4'd2,
    SLOT_MPLL  = 4'd3,
    SLOT_SPLL  = 4'd4,
    SLOT_GATE0 = 4'd5,
    SLOT_GATE1 = 4'd6,
    SLOT_GATE2 = 4'd7,
    SLOT_PMR   = 4'd8
  } slot_e;

  localparam int              RO_WORD  = 18;
  localparam logic [DATA_W-1:0] RO_VALUE = 32'h0000_4040;

  // PLL control word packing: [29:26] pre-divider, [25:16] denominator,
  // [13:10] integer part, [9:0] numerator.
  function automatic logic [DATA_W-1:0] pll_word(input logic [3:0] pd,
                                                 input logic [9:0] mfd,
                                                 input logic [3:0] mfi,
                                                 input logic [9:0] mfn);
    return {2'b00, pd, mfd, 2'b00, mfi, mfn};
  endfunction

  function automatic int slot_word(input int s);
    case (s)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      3:       return 4;
      4:       return 6;
      5:       return 8;
      6:       return 9;
      7:       return 10;
      default: return 23;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slot_mask(input int s);
    case (s)
      0:       return 32'h3b6f_dfff;
      1:       return 32'hff9f_3fff;
      3, 4:    return 32'hbfff_3fff;
      8:       return 32'h0000_0000;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slot_force(input int s);
    return (s == 0) ? 32'h0400_0000 : 32'h0000_0000;
  endfunction

  function automatic logic [DATA_W-1:0] slot_reset(input int s);
    case (s)
      0:       return 32'h074b_0b7b;
      1:       return 32'hff87_0b48;
      2:       return 32'h49fc_fe7f;
      3:       return pll_word(4'd1, 10'd0, 4'd6, 10'd0);
      4:       return pll_word(4'd1, 10'd4, 4'd12, 10'd1);
      8:       return 32'h8020_9828;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  function automatic logic slot_writable(input int s);
    return s != 8;
  endfunction

  function automatic logic [NUM_SLOTS-1:0] recalc_set();
    logic [NUM_SLOTS-1:0] m;
    m = '0;
    for (int i = 0; i <= 4; i++) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode
  import clkctl_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic [WORD_W-1:0]    word,
  output logic [NUM_SLOTS-1:0] slot_hit,
  output logic                 ro_hit
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hit
    assign slot_hit[g] = (int'(word) == slot_word(g));
  end

  assign ro_hit = (int'(word) == RO_WORD);

endmodule

// File: rtl/clkctl_field.sv
module clkctl_field
  import clkctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VAL = '0,
  parameter logic [DATA_W-1:0] MASK      = '1,
  parameter logic [DATA_W-1:0] FORCE     = '0,
  parameter bit                WRITABLE  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RESET_VAL;
    end else if (we && WRITABLE) begin
      q <= (wdata & MASK) | FORCE;
    end
  end

endmodule

// File: rtl/clkctl_rdport.sv
module clkctl_rdport
  import clkctl_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rd,
  input  logic [NUM_SLOTS-1:0]              slot_hit,
  input  logic                              ro_hit,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  slot_q,
  output logic [DATA_W-1:0]                 rdata,
  output logic                              rvalid
);

  logic [DATA_W-1:0] mux;

  always_comb begin
    mux = ro_hit ? RO_VALUE : '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slot_hit[i]) mux = mux | slot_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= mux;
    end
  end

endmodule

// File: rtl/clkctl_recalc.sv
module clkctl_recalc (
  input  logic clk,
  input  logic rst,
  input  logic cfg_write,
  output logic pulse
);

  logic boot_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_pend <= 1'b1;
      pulse     <= 1'b0;
    end else begin
      boot_pend <= 1'b0;
      pulse     <= boot_pend | cfg_write;
    end
  end

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              recalc_pulse,
  output logic [31:0]       mode_o,
  output logic [31:0]       div0_o,
  output logic [31:0]       div1_o,
  output logic [31:0]       mpll_o,
  output logic [31:0]       spll_o
);

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [NUM_SLOTS-1:0] RECALC_SET = recalc_set();

  logic [WORD_W-1:0]               word;
  logic                            unused_lsb;
  logic [NUM_SLOTS-1:0]            slot_hit;
  logic                            ro_hit;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q;
  logic                            cfg_write;

  assign word       = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];

  clkctl_decode #(.WORD_W(WORD_W)) u_dec (
    .word     (word),
    .slot_hit (slot_hit),
    .ro_hit   (ro_hit)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    clkctl_field #(
      .RESET_VAL (slot_reset(g)),
      .MASK      (slot_mask(g)),
      .FORCE     (slot_force(g)),
      .WRITABLE  (slot_writable(g))
    ) u_fld (
      .clk   (clk),
      .rst   (rst),
      .we    (bus_wr & slot_hit[g]),
      .wdata (bus_wdata),
      .q     (slot_q[g])
    );
  end

  assign cfg_write = bus_wr & (|(slot_hit & RECALC_SET));

  clkctl_recalc u_recalc (
    .clk       (clk),
    .rst       (rst),
    .cfg_write (cfg_write),
    .pulse     (recalc_pulse)
  );

  clkctl_rdport u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd       (bus_rd),
    .slot_hit (slot_hit),
    .ro_hit   (ro_hit),
    .slot_q   (slot_q),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );

  assign mode_o = slot_q[int'(SLOT_MODE)];
  assign div0_o = slot_q[int'(SLOT_DIV0)];
  assign div1_o = slot_q[int'(SLOT_DIV1)];
  assign mpll_o = slot_q[int'(SLOT_MPLL)];
  assign spll_o = slot_q[int'(SLOT_SPLL)];

endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              recalc_pulse,
  input logic [31:0]       mode_o
);

  logic [ADDR_W-3:0] w;
  logic              cfg_w;
  logic              gate_w;
  logic              prev_rst;

  assign w      = bus_addr[ADDR_W-1:2];
  assign cfg_w  = (w == 0) || (w == 1) || (w == 2) || (w == 4) || (w == 6);
  assign gate_w = (w == 8) || (w == 9) || (w == 10);

  always_ff @(posedge clk) prev_rst <= rst;

  assert_cfg_write_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && cfg_w) |=> recalc_pulse);

  assert_idle_no_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr && !prev_rst) |=> !recalc_pulse);

  assert_gate_no_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && gate_w && !prev_rst) |=> !recalc_pulse);

  assert_boot_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    prev_rst |=> recalc_pulse);

  assert_read_valid_R8: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  assert_pm_constant_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && w == 23) |=> (bus_rdata == 32'h8020_9828));

  assert_ro_word_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && w == 18) |=> (bus_rdata == 32'h0000_4040));

  assert_mode_write_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && w == 0) |=>
      (mode_o == (($past(bus_wdata) & 32'h3b6f_dfff) | 32'h0400_0000)));

endmodule

bind clkctl_regbank clkctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .bus_rvalid   (bus_rvalid),
  .recalc_pulse (recalc_pulse),
  .mode_o       (mode_o)
);

// File: tb/clkctl_regbank_bench.sv
`timescale 1ns/1ps
module clkctl_regbank_bench;

  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic          recalc_pulse;
  logic [31:0]   mode_o, div0_o, div1_o, mpll_o, spll_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  clkctl_regbank #(.ADDR_W(AW)) u_clkctl_regbank (
    .clk (clk), .rst (rst), .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .bus_rvalid (bus_rvalid), .recalc_pulse (recalc_pulse),
    .mode_o (mode_o), .div0_o (div0_o), .div1_o (div1_o),
    .mpll_o (mpll_o), .spll_o (spll_o)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expected item per valid read result.
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected valid", bus_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  task automatic bus_read(input logic [AW-1:0] a, input logic [31:0] e,
                          input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d,
                           input bit pulse, input string t);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    check(recalc_pulse === pulse, t, 32'(recalc_pulse), 32'(pulse));
    @(negedge clk);
    check(recalc_pulse === 1'b0, {t, " (R9 strobe one cycle)"},
          32'(recalc_pulse), 32'h0);
  endtask

  task automatic bus_rdwr(input logic [AW-1:0] a, input logic [31:0] d,
                          input logic [31:0] old_v, input string t);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = a; bus_wdata = d;
    exp_q.push_back(old_v); tag_q.push_back(t);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual 0x00000000 expected 0x00000001");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(recalc_pulse === 1'b0, "R10 low during reset", 32'(recalc_pulse), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(recalc_pulse === 1'b1, "R10 boot strobe", 32'(recalc_pulse), 32'h1);
    @(negedge clk);
    check(recalc_pulse === 1'b0, "R10 boot strobe one cycle", 32'(recalc_pulse), 32'h0);
    check(mode_o === 32'h074b0b7b, "R12 mode_o after reset", mode_o, 32'h074b0b7b);
    check(spll_o === 32'h04043001, "R12 spll_o after reset", spll_o, 32'h04043001);

    // R1 reset values
    bus_read(12'h000, 32'h074b0b7b, "R1 mode reset");
    bus_read(12'h004, 32'hff870b48, "R1 div0 reset");
    bus_read(12'h008, 32'h49fcfe7f, "R1 div1 reset");
    bus_read(12'h010, 32'h04001800, "R1 main PLL reset");
    bus_read(12'h018, 32'h04043001, "R1 system PLL reset");
    bus_read(12'h020, 32'hffffffff, "R1 gate0 reset");
    bus_read(12'h024, 32'hffffffff, "R1 gate1 reset");
    bus_read(12'h028, 32'hffffffff, "R1 gate2 reset");
    bus_read(12'h05c, 32'h80209828, "R1 power word reset");
    bus_read(12'h048, 32'h00004040, "R7 read-only word");
    bus_read(12'h00c, 32'h00000000, "R7 unmapped word 3");

    // R2 mode mask and forced bit
    bus_write(12'h000, 32'hffffffff, 1'b1, "R9 strobe after mode write");
    bus_read(12'h000, 32'h3f6fdfff, "R2 mode all ones");
    bus_write(12'h000, 32'h00000000, 1'b1, "R9 strobe after mode write");
    bus_read(12'h000, 32'h04000000, "R2 mode zeros keeps bit 26");
    check(mode_o === 32'h04000000, "R12 mode_o follows", mode_o, 32'h04000000);

    // R3 divider words
    bus_write(12'h004, 32'hffffffff, 1'b1, "R9 strobe after div0 write");
    bus_read(12'h004, 32'hff9f3fff, "R3 div0 mask");
    check(div0_o === 32'hff9f3fff, "R12 div0_o follows", div0_o, 32'hff9f3fff);
    bus_write(12'h008, 32'h12345678, 1'b1, "R9 strobe after div1 write");
    bus_read(12'h008, 32'h12345678, "R3 div1 full");

    // R4 PLL words
    bus_write(12'h010, 32'hffffffff, 1'b1, "R9 strobe after main PLL write");
    bus_read(12'h010, 32'hbfff3fff, "R4 main PLL mask");
    check(mpll_o === 32'hbfff3fff, "R12 mpll_o follows", mpll_o, 32'hbfff3fff);
    bus_write(12'h018, 32'h40004000, 1'b1, "R9 strobe after system PLL write");
    bus_read(12'h018, 32'h00000000, "R4 system PLL masked-off bits dropped");

    // R5 gating words
    bus_write(12'h020, 32'h00000000, 1'b0, "R5 no strobe on gate0 write");
    bus_read(12'h020, 32'h00000000, "R5 gate0 full");
    bus_write(12'h028, 32'ha5a5a5a5, 1'b0, "R5 no strobe on gate2 write");
    bus_read(12'h028, 32'ha5a5a5a5, "R5 gate2 full");
    bus_read(12'h024, 32'hffffffff, "R5 gate1 untouched");

    // R6 power word is read-only
    bus_write(12'h05c, 32'h00000000, 1'b0, "R6 no strobe on power write");
    bus_read(12'h05c, 32'h80209828, "R6 power word unchanged");

    // R7 unmapped writes
    bus_write(12'h048, 32'h00000000, 1'b0, "R7 no strobe on read-only write");
    bus_read(12'h048, 32'h00004040, "R7 read-only word unchanged");
    bus_write(12'h014, 32'hdeadbeef, 1'b0, "R7 no strobe on unmapped write");
    bus_read(12'h014, 32'h00000000, "R7 unmapped word reads zero");
    bus_read(12'h004, 32'hff9f3fff, "R7 neighbour div0 unchanged");

    // R11 low address bits ignored
    bus_read(12'h006, 32'hff9f3fff, "R11 div0 with low bits 2");
    bus_write(12'h00b, 32'hcafef00d, 1'b1, "R11 strobe on div1 via low bits 3");
    bus_read(12'h009, 32'hcafef00d, "R11 div1 via low bits 1");

    // R8 read and write in the same cycle
    bus_rdwr(12'h008, 32'h0badf00d, 32'hcafef00d, "R8 same-cycle read gives old");
    check(recalc_pulse === 1'b1, "R9 strobe after same-cycle write", 32'(recalc_pulse), 32'h1);
    bus_read(12'h008, 32'h0badf00d, "R8 new value after same-cycle write");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8 all reads answered", 32'(exp_q.size()), 32'h0);
    finish_run();
  end

endmodule